// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block drives an active-low reset line into a microcontroller. It watches two things. The first is a kick input that the software toggles to show it is alive. The second is a set of generic fault flags. When the kicks stop for longer than a timeout, the reset line produces a repeating train of short low pulses. The train continues until a kick arrives during one of the high gaps. When any fault flag is raised, the line goes low and stays low while the fault lasts. After the fault clears, the line stays low for one more reset period before it releases. A level fault always wins over the pulse train.

All durations come from one timing base. A two-bit scale setting selects one of four points, each giving a timeout in units and a pulse width in units. One unit equals `UNIT_CYCLES` clock cycles. The timeout and the post-fault reset period are the same length. The kick input is asynchronous and passes through a synchronizer. The fault flags are taken to be synchronous to `clk`. A watchdog-disable input keeps the timeout from ever expiring. A synchronous reset starts the block in the reset-stretch phase, so the microcontroller always sees one full reset period at start-up.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high, `mcu_rst_n` is low. After the last clock edge that samples `rst` high, `mcu_rst_n` stays low and rises at the T-th following edge, where T is the timeout in cycles.
- R2: When any bit of `fault_flags` is sampled high at an edge, `mcu_rst_n` is low after that edge. It stays low for as long as at least one bit is set.
- R3: Take the first edge that samples all fault flags clear. `mcu_rst_n` rises at the T-th edge after it.
- R4: T equals units × `UNIT_CYCLES` and the pulse width P equals units × `UNIT_CYCLES`. For `scale_sel` = 0, 1, 2 and 3, T uses 20, 44, 94 and 200 units and P uses 1, 3, 7 and 14 units.
- R5: While released, with no kick event and no disable, `mcu_rst_n` falls T edges after it rose or after the last kick event.
- R6: Once the timeout has expired, `mcu_rst_n` repeats a pattern of P cycles low followed by T cycles high for as long as no kick arrives.
- R7: A rising edge on `wd_kick` becomes a one-cycle kick event, two clock edges after the edge that first samples it high. A kick event restarts the timeout while the line is released, and it ends the pulse train when it lands in a high gap. A kick event that lands during a low pulse is ignored.
- R8: While `wd_disable` is high the watchdog timeout never expires and `mcu_rst_n` stays high if no fault is present. When `wd_disable` goes low, a full timeout T starts.
- R9: A fault that arrives during the pulse train replaces it with a steady low level, followed by the post-fault period of R3.
- R10: Holding `wd_kick` high produces only one kick event. A new event needs the input to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wd_kick | input | 1 | Asynchronous liveness kick from software, rising edge counts |
| wd_disable | input | 1 | Suppresses watchdog expiry while high |
| fault_flags | input | NFLT | Synchronous fault indications, any set bit forces reset |
| scale_sel | input | 2 | Timing scale point, 0 to 3 |
| mcu_rst_n | output | 1 | Active-low reset to the microcontroller |

## Verification
A stuck or mis-sequenced controller state shows up at the reset pin within one timeout period. If the pin stays high too long, the timeout counter missed a wrap. If it stays low, the pulse or stretch phase never terminated. An off-by-one in the interval counter changes every measured low or high run by whole cycles, so the bench measures each run's exact length at every scale point. A kick detector that fires on levels rather than edges stretches the high phase when the kick is held, which the held-kick sweep exposes in the next pulse.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [2:0] {
    SV_STRETCH = 3'd0,
    SV_FAULT   = 3'd1,
    SV_RUN     = 3'd2,
    SV_WD_LOW  = 3'd3,
    SV_WD_HIGH = 3'd4
  } sv_state_e;

  localparam int unsigned MAX_TIMEOUT_UNITS = 200;

  // Timeout (and post-fault stretch) length in units for a scale point.
  function automatic int unsigned scale_timeout_units(input logic [1:0] sel);
    case (sel)
      2'd0:    return 20;
      2'd1:    return 44;
      2'd2:    return 94;
      default: return 200;
    endcase
  endfunction

  // Low-pulse width in units during the watchdog train.
  function automatic int unsigned scale_pulse_units(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 3;
      2'd2:    return 7;
      default: return 14;
    endcase
  endfunction

  // Phases in which the reset line is released.
  function automatic logic state_releases(input sv_state_e s);
    return (s == SV_RUN) || (s == SV_WD_HIGH);
  endfunction

endpackage

// File: rtl/sup_kick_sync.sv
module sup_kick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic kick_evt
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN-2:0], async_in};
  end

  // Synchronized level is the last sync stage; the extra flop holds its history.
  assign kick_evt = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
endmodule

// File: rtl/sup_interval_timer.sv
module sup_interval_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          done,
  output logic [CW-1:0] count
);
  logic [CW:0] next_count;

  assign next_count = {1'b0, count} + {{CW{1'b0}}, 1'b1};
  // Terminal when this cycle is the limit-th one of the interval.
  assign done = next_count >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (rst || clr || done) count <= '0;
    else                    count <= next_count[CW-1:0];
  end
endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
  import sup_pkg::*;
#(
  parameter int CW          = 10,
  parameter int UNIT_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fault_any,
  input  logic          kick_evt,
  input  logic          wd_disable,
  input  logic [1:0]    scale_sel,
  input  logic          tmr_done,
  output logic          tmr_clr,
  output logic [CW-1:0] tmr_limit,
  output logic [CW-1:0] t_lim,
  output logic [CW-1:0] p_lim,
  output sv_state_e     state,
  output logic          rst_n_q
);
  sv_state_e nxt;
  logic      wd_hold;

  assign t_lim = CW'(scale_timeout_units(scale_sel) * UNIT_CYCLES);
  assign p_lim = CW'(scale_pulse_units(scale_sel) * UNIT_CYCLES);
  assign tmr_limit = (state == SV_WD_LOW) ? p_lim : t_lim;
  assign wd_hold = kick_evt | wd_disable;

  always_comb begin
    nxt     = state;
    tmr_clr = 1'b0;
    if (fault_any) begin
      nxt     = SV_FAULT;
      tmr_clr = 1'b1;
    end else begin
      case (state)
        SV_FAULT: begin
          nxt     = SV_STRETCH;
          tmr_clr = 1'b1;
        end
        SV_STRETCH: if (tmr_done) nxt = SV_RUN;
        SV_RUN: begin
          if (wd_hold)       tmr_clr = 1'b1;
          else if (tmr_done) nxt = SV_WD_LOW;
        end
        SV_WD_LOW: if (tmr_done) nxt = SV_WD_HIGH;
        SV_WD_HIGH: begin
          if (wd_hold) begin
            nxt     = SV_RUN;
            tmr_clr = 1'b1;
          end else if (tmr_done) begin
            nxt = SV_WD_LOW;
          end
        end
        default: begin
          nxt     = SV_STRETCH;
          tmr_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SV_STRETCH;
      rst_n_q <= 1'b0;
    end else begin
      state   <= nxt;
      rst_n_q <= state_releases(nxt);
    end
  end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import sup_pkg::*;
#(
  parameter int NFLT        = 3,
  parameter int UNIT_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wd_kick,
  input  logic            wd_disable,
  input  logic [NFLT-1:0] fault_flags,
  input  logic [1:0]      scale_sel,
  output logic            mcu_rst_n
);
  localparam int MAX_CYC = MAX_TIMEOUT_UNITS * UNIT_CYCLES;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic          fault_any;
  logic          kick_evt;
  logic          tmr_clr;
  logic          tmr_done;
  logic [CW-1:0] tmr_limit;
  logic [CW-1:0] tmr_cnt;
  logic [CW-1:0] t_lim;
  logic [CW-1:0] p_lim;
  sv_state_e     state;

  assign fault_any = |fault_flags;

  sup_kick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_kick (
    .clk      (clk),
    .rst      (rst),
    .async_in (wd_kick),
    .kick_evt (kick_evt)
  );

  sup_interval_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (tmr_clr),
    .limit (tmr_limit),
    .done  (tmr_done),
    .count (tmr_cnt)
  );

  sup_ctrl #(.CW(CW), .UNIT_CYCLES(UNIT_CYCLES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .fault_any  (fault_any),
    .kick_evt   (kick_evt),
    .wd_disable (wd_disable),
    .scale_sel  (scale_sel),
    .tmr_done   (tmr_done),
    .tmr_clr    (tmr_clr),
    .tmr_limit  (tmr_limit),
    .t_lim      (t_lim),
    .p_lim      (p_lim),
    .state      (state),
    .rst_n_q    (mcu_rst_n)
  );
endmodule

// File: rtl/sup_checker.sv
module sup_checker
  import sup_pkg::*;
#(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          fault_any,
  input logic          kick_evt,
  input logic          wd_disable,
  input logic          mcu_rst_n,
  input sv_state_e     state,
  input logic          tmr_done,
  input logic [CW-1:0] tmr_cnt,
  input logic [CW-1:0] t_lim,
  input logic [CW-1:0] p_lim
);
  logic [CW:0] low_len;
  logic        prev_wd_low;
  logic        prev_stretch;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_len      <= '0;
      prev_wd_low  <= 1'b0;
      prev_stretch <= 1'b0;
    end else begin
      if (mcu_rst_n)      low_len <= '0;
      else if (!(&low_len)) low_len <= low_len + 1'b1;
      prev_wd_low  <= (state == SV_WD_LOW);
      prev_stretch <= (state == SV_STRETCH);
    end
  end

  p_fault_low_r2: assert property (@(posedge clk) disable iff (rst)
    fault_any |=> !mcu_rst_n);

  p_stretch_start_r3: assert property (@(posedge clk) disable iff (rst)
    (!fault_any && $past(fault_any)) |-> !mcu_rst_n);

  p_stretch_len_r1: assert property (@(posedge clk) disable iff (rst)
    (mcu_rst_n && prev_stretch && low_len != '0) |-> (low_len >= {1'b0, t_lim}));

  p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
    (mcu_rst_n && prev_wd_low && low_len != '0) |-> (low_len == {1'b0, p_lim}));

  p_kick_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (kick_evt && mcu_rst_n && !fault_any) |=> mcu_rst_n);

  p_pulse_ignores_kick_r7: assert property (@(posedge clk) disable iff (rst)
    (state == SV_WD_LOW && !fault_any && !tmr_done) |=> !mcu_rst_n);

  p_disable_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (wd_disable && mcu_rst_n && !fault_any) |=> mcu_rst_n);

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    tmr_cnt < t_lim);
endmodule

bind rst_supervisor sup_checker #(.CW(CW)) u_sup_chk (
  .clk        (clk),
  .rst        (rst),
  .fault_any  (fault_any),
  .kick_evt   (kick_evt),
  .wd_disable (wd_disable),
  .mcu_rst_n  (mcu_rst_n),
  .state      (state),
  .tmr_done   (tmr_done),
  .tmr_cnt    (tmr_cnt),
  .t_lim      (t_lim),
  .p_lim      (p_lim)
);

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int NF         = 3;
  localparam int UC         = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wd_kick = 1'b0;
  logic          wd_disable = 1'b0;
  logic [NF-1:0] fault_flags = '0;
  logic [1:0]    scale_sel = 2'd0;
  logic          mcu_rst_n;

  int checks = 0;
  int errors = 0;

  rst_supervisor #(.NFLT(NF), .UNIT_CYCLES(UC)) i_rst_supervisor (
    .clk         (clk),
    .rst         (rst),
    .wd_kick     (wd_kick),
    .wd_disable  (wd_disable),
    .fault_flags (fault_flags),
    .scale_sel   (scale_sel),
    .mcu_rst_n   (mcu_rst_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Timeout units grow roughly geometrically; pulse is the rounded 14/200 share.
  function automatic int exp_timeout(input int s);
    int u;
    u = (s == 0) ? 20 : (s == 1) ? 44 : (s == 2) ? 94 : 200;
    return u * UC;
  endfunction

  function automatic int exp_pulse(input int s);
    int u;
    u = (s == 0) ? 20 : (s == 1) ? 44 : (s == 2) ? 94 : 200;
    return ((u * 14 + 100) / 200) * UC;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Count consecutive negedge samples at level lvl, starting with the current one.
  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (mcu_rst_n === lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int tt;
    int pp;
    int lows;
    for (int s = 0; s < 4; s++) begin
      tt = exp_timeout(s);
      pp = exp_pulse(s);
      rst = 1'b1; scale_sel = 2'(s); wd_kick = 1'b0; wd_disable = 1'b0; fault_flags = '0;
      repeat (3) @(negedge clk);
      chk(mcu_rst_n === 1'b0, "R1", "low during reset", int'(mcu_rst_n), 0);
      rst = 1'b0;
      run_len(1'b0, n); chk(n == tt, "R1", "startup stretch", n, tt);
      run_len(1'b1, n); chk(n == tt, "R5", "first timeout R4", n, tt);
      run_len(1'b0, n); chk(n == pp, "R6", "pulse width R4", n, pp);
      run_len(1'b1, n); chk(n == tt, "R6", "gap length", n, tt);
      run_len(1'b0, n); chk(n == pp, "R6", "second pulse", n, pp);

      // Kick in a high gap three samples in; held high afterwards.
      repeat (3) @(negedge clk);
      wd_kick = 1'b1;
      run_len(1'b1, n); chk(n == tt + 3, "R7", "kick ends train", n, tt + 3);
      run_len(1'b0, n); chk(n == pp, "R10", "held kick no new event", n, pp);
      wd_kick = 1'b0;
      run_len(1'b1, n); chk(n == tt, "R10", "falling kick no event", n, tt);

      // Kick during a low pulse is ignored (pulse long enough from scale 1 up).
      if (s >= 1) begin
        wd_kick = 1'b1;
        @(negedge clk);
        wd_kick = 1'b0;
        run_len(1'b0, n); chk(n + 1 == pp, "R7", "pulse ignores kick", n + 1, pp);
        run_len(1'b1, n); chk(n == tt, "R7", "gap after ignored kick", n, tt);
      end else begin
        run_len(1'b0, n); chk(n == pp, "R6", "pulse", n, pp);
        run_len(1'b1, n); chk(n == tt, "R6", "gap", n, tt);
      end
      run_len(1'b0, n);

      // Disable during a high gap.
      wd_disable = 1'b1;
      lows = 0;
      for (int i = 0; i < 3 * tt; i++) begin
        @(negedge clk);
        if (mcu_rst_n !== 1'b1) lows++;
      end
      chk(lows == 0, "R8", "no expiry while disabled", lows, 0);
      wd_disable = 1'b0;
      run_len(1'b1, n); chk(n == tt, "R8", "timeout after re-enable", n, tt);

      // Fault arriving in a watchdog pulse.
      fault_flags = NF'(1) << (s % NF);
      lows = 0;
      for (int i = 0; i < pp + tt + 5; i++) begin
        @(negedge clk);
        if (mcu_rst_n === 1'b0) lows++;
      end
      chk(lows == pp + tt + 5, "R9", "steady low under fault", lows, pp + tt + 5);
      fault_flags = '0;
      run_len(1'b0, n); chk(n == tt + 1, "R3", "post-fault stretch", n, tt + 1);
      run_len(1'b1, n); chk(n == tt, "R5", "timeout after stretch", n, tt);
      run_len(1'b0, n);

      // Several flags set in a gap, cleared one at a time.
      fault_flags = '1;
      @(negedge clk);
      chk(mcu_rst_n === 1'b0, "R2", "low after fault", int'(mcu_rst_n), 0);
      for (int b = 0; b < NF; b++) begin
        fault_flags[b] = 1'b0;
        if (b < NF - 1) begin
          @(negedge clk);
          chk(mcu_rst_n === 1'b0, "R2", "low while a flag remains", int'(mcu_rst_n), 0);
        end
      end
      run_len(1'b0, n); chk(n == tt + 1, "R3", "stretch after last flag", n, tt + 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule